// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pairing Logic

This block is the issue stage of a statically scheduled two-way superscalar core. Each accepted fetch word is 64 bits wide and holds two 32-bit instructions. The lower half is the left (older) slot and the upper half is the right (younger) slot. The block keeps the word and decodes the class of each instruction. It compares the register specifiers of the pair and checks every register an instruction touches against two busy masks, one for the integer file and one for the FP file. These masks come from the interlock logic further down the pipe. From this it decides, each cycle, whether the left, the right, both or neither instruction issues.

A pair issues together only when the left slot holds an integer-class instruction and the right slot holds an FP operation. Loads, stores and branches count as integer-class, and this includes FP loads and FP stores that move FP data. The pair must also be free of any dependence inside the bundle, and neither instruction may be blocked. Issue is strictly in order: the right instruction never leaves before the left one. An instruction that does not issue stays in the held bundle. A new bundle is accepted only once both slots have been consumed, and this can happen in the same cycle that the last held instruction issues. An external stall holds everything back for the cycle.

For the full pair rate the register files need four read ports and two write ports in total. An FP load paired with an FP operation also needs an extra write port on the FP file.

Top module: `dual_issue_pair`

## Requirements
- R1: After reset nothing is held, neither issue output is high, and `fetch_ready_o` is high.
- R2: A bundle is captured on a clock edge where `fetch_valid_i` and `fetch_ready_o` are both high. Bits [31:0] become the left instruction and bits [63:32] the right instruction. From the next cycle on, both are shown on `left_instr_o` and `right_instr_o`, and both slots are pending.
- R3: Instruction fields are: class = bits [31:30], store flag = bit 29, FP-data flag = bit 28, rd = [25:21], rs1 = [20:16], rs2 = [15:11]. The classes are 00 integer ALU, 01 memory, 10 branch and 11 FP operation. Classes 00, 01 and 10 are integer-class; class 11 is FP-class.
- R4: When both slots are pending, stall is low, the left slot is integer-class, the right slot is FP-class, neither instruction is blocked and there is no pair dependence, both issue outputs are high in the same cycle.
- R5: When both slots are pending and the left slot is not integer-class or the right slot is not FP-class, only the left instruction may issue.
- R6: When the left slot is an FP load (class 01, bit 29 low, bit 28 high) and its rd equals the rs1, rs2 or rd of the right FP operation, only the left instruction issues.
- R7: An instruction is blocked, and does not issue, while any register it uses is set in the busy mask of that register's file. The registers used are: integer ALU reads rs1 and rs2 and writes rd, all in the integer file. A load reads rs1 (integer) and writes rd, which is FP when bit 28 is set. A store reads rs1 (integer) and rs2, which is FP when bit 28 is set. A branch reads rs1 and rs2 (integer). An FP operation uses rd, rs1 and rs2, all in the FP file.
- R8: The right instruction never issues in a cycle where the left slot is pending and does not issue.
- R9: An instruction that does not issue stays pending. Once the left slot has been consumed, the remaining right instruction issues on its own, whatever its class, in the first cycle it is not blocked and stall is low.
- R10: `fetch_ready_o` is high exactly when no instruction will remain pending after this cycle's issue. A new bundle can therefore be captured on the same edge on which the last pending instruction issues.
- R11: While `stall_i` is high, neither issue output is high and the held bundle and its pending state stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | A fetch bundle is offered |
| fetch_bundle_i | input | 64 | Two instructions; the left slot is in the lower half |
| fetch_ready_o | output | 1 | A bundle offered this cycle will be captured |
| stall_i | input | 1 | Suppresses all issue this cycle |
| int_busy_i | input | 32 | One bit per integer register with a write still pending |
| fp_busy_i | input | 32 | One bit per FP register with a write still pending |
| issue_left_o | output | 1 | The left instruction issues this cycle |
| issue_right_o | output | 1 | The right instruction issues this cycle |
| left_instr_o | output | 32 | Held left instruction |
| right_instr_o | output | 32 | Held right instruction |

## Verification
The pending bits are the only state besides the held bundle, and a wrong value shows at the ports within one cycle. An instruction that was wrongly dropped lets `fetch_ready_o` rise one cycle too early. A bit that wrongly stays set makes an instruction issue twice in the next drain cycle, or leaves `fetch_ready_o` low after a full issue. The bench sweeps every pairing of seven instruction kinds against several specifier overlaps, busy masks and stall. For each case it checks the first cycle's issue pair, the ready flag and the drain cycle after it, so a lost or duplicated pending bit is caught on the second cycle of the case.

// File: rtl/pairing_pkg.sv
package pairing_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int CTL_W   = 4;  // class(2), store flag, fp-data flag
  localparam int SLOTS   = 2;

  typedef enum logic [1:0] {
    CLS_ALU = 2'b00,
    CLS_MEM = 2'b01,
    CLS_BR  = 2'b10,
    CLS_FP  = 2'b11
  } cls_e;
endpackage

// File: rtl/slot_decode.sv
module slot_decode
  import pairing_pkg::*;
#(
  parameter int NREG = 32,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic [CTL_W-1:0]   ctl_i,
  input  logic [3*REG_W-1:0] regs_i,
  output logic               int_class_o,
  output logic [REG_W-1:0]   rd_o,
  output logic [REG_W-1:0]   rs1_o,
  output logic [REG_W-1:0]   rs2_o,
  output logic               rd_we_o,
  output logic               rd_fp_o,
  output logic               rs1_re_o,
  output logic               rs2_re_o,
  output logic               rs2_fp_o,
  output logic               rs1_fp_o
);
  cls_e cls;
  logic is_store, fp_data;

  assign cls      = cls_e'(ctl_i[CTL_W-1 -: 2]);
  assign is_store = ctl_i[1];
  assign fp_data  = ctl_i[0];

  assign rd_o  = regs_i[3*REG_W-1 -: REG_W];
  assign rs1_o = regs_i[2*REG_W-1 -: REG_W];
  assign rs2_o = regs_i[REG_W-1:0];

  always_comb begin
    int_class_o = (cls != CLS_FP);
    rd_we_o  = 1'b0;
    rd_fp_o  = 1'b0;
    rs1_re_o = 1'b0;
    rs1_fp_o = 1'b0;
    rs2_re_o = 1'b0;
    rs2_fp_o = 1'b0;
    unique case (cls)
      CLS_ALU: begin
        rd_we_o  = 1'b1;
        rs1_re_o = 1'b1;
        rs2_re_o = 1'b1;
      end
      CLS_MEM: begin
        rs1_re_o = 1'b1;
        if (is_store) begin
          rs2_re_o = 1'b1;
          rs2_fp_o = fp_data;
        end else begin
          rd_we_o  = 1'b1;
          rd_fp_o  = fp_data;
        end
      end
      CLS_BR: begin
        rs1_re_o = 1'b1;
        rs2_re_o = 1'b1;
      end
      CLS_FP: begin
        rd_we_o  = 1'b1;
        rd_fp_o  = 1'b1;
        rs1_re_o = 1'b1;
        rs1_fp_o = 1'b1;
        rs2_re_o = 1'b1;
        rs2_fp_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/busy_check.sv
module busy_check #(
  parameter int NREG = 32,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic [REG_W-1:0] rd_i,
  input  logic [REG_W-1:0] rs1_i,
  input  logic [REG_W-1:0] rs2_i,
  input  logic             rd_we_i,
  input  logic             rd_fp_i,
  input  logic             rs1_re_i,
  input  logic             rs1_fp_i,
  input  logic             rs2_re_i,
  input  logic             rs2_fp_i,
  input  logic [NREG-1:0]  int_busy_i,
  input  logic [NREG-1:0]  fp_busy_i,
  output logic             blocked_o
);
  function automatic logic hit(input logic used, input logic fp,
                               input logic [REG_W-1:0] idx,
                               input logic [NREG-1:0] ib,
                               input logic [NREG-1:0] fb);
    return used && (fp ? fb[idx] : ib[idx]);
  endfunction

  assign blocked_o = hit(rd_we_i,  rd_fp_i,  rd_i,  int_busy_i, fp_busy_i)
                   | hit(rs1_re_i, rs1_fp_i, rs1_i, int_busy_i, fp_busy_i)
                   | hit(rs2_re_i, rs2_fp_i, rs2_i, int_busy_i, fp_busy_i);
endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl #(
  parameter int BUNDLE_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fetch_valid_i,
  input  logic [BUNDLE_W-1:0] fetch_bundle_i,
  input  logic                stall_i,
  input  logic                left_int_i,
  input  logic                right_fp_i,
  input  logic                pair_dep_i,
  input  logic                left_blocked_i,
  input  logic                right_blocked_i,
  output logic                fetch_ready_o,
  output logic                issue_left_o,
  output logic                issue_right_o,
  output logic [BUNDLE_W-1:0] bundle_o
);
  logic [1:0]          pend_q, remain;
  logic [BUNDLE_W-1:0] bundle_q;
  logic                pair_ok, accept;

  assign pair_ok = left_int_i && right_fp_i && !pair_dep_i;

  always_comb begin
    issue_left_o  = !stall_i && pend_q[0] && !left_blocked_i;
    issue_right_o = !stall_i && pend_q[1] && !right_blocked_i &&
                    (pend_q[0] ? (issue_left_o && pair_ok) : 1'b1);
  end

  assign remain        = pend_q & ~{issue_right_o, issue_left_o};
  assign fetch_ready_o = (remain == 2'b00);
  assign accept        = fetch_valid_i && fetch_ready_o;
  assign bundle_o      = bundle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 2'b00;
      bundle_q <= '0;
    end else if (accept) begin
      pend_q   <= 2'b11;
      bundle_q <= fetch_bundle_i;
    end else begin
      pend_q   <= remain;
    end
  end

  // R11
  stall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (!issue_left_o && !issue_right_o));

  // R11
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && pend_q != 2'b00) |=> ($stable(pend_q) && $stable(bundle_q)));

  // R8
  in_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_right_o && !issue_left_o) |-> !pend_q[0]);

  // R9
  held_bundle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_ready_o |=> $stable(bundle_q));

  // R7
  blocked_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_left_o |-> !left_blocked_i);

  // R10
  pending_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_left_o |-> pend_q[0]) and (issue_right_o |-> pend_q[1]));

  // R2
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_ready_o) |=> (pend_q == 2'b11));
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import pairing_pkg::*;
#(
  parameter int NREG = 32,
  localparam int REG_W    = $clog2(NREG),
  localparam int BUNDLE_W = SLOTS * INSTR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fetch_valid_i,
  input  logic [BUNDLE_W-1:0] fetch_bundle_i,
  output logic                fetch_ready_o,
  input  logic                stall_i,
  input  logic [NREG-1:0]     int_busy_i,
  input  logic [NREG-1:0]     fp_busy_i,
  output logic                issue_left_o,
  output logic                issue_right_o,
  output logic [INSTR_W-1:0]  left_instr_o,
  output logic [INSTR_W-1:0]  right_instr_o
);
  logic [BUNDLE_W-1:0] bundle;
  logic                int_cls [SLOTS];
  logic [REG_W-1:0]    rd [SLOTS], rs1 [SLOTS], rs2 [SLOTS];
  logic                rd_we [SLOTS], rd_fp [SLOTS];
  logic                rs1_re [SLOTS], rs1_fp [SLOTS];
  logic                rs2_re [SLOTS], rs2_fp [SLOTS];
  logic                blocked [SLOTS];
  logic                pair_dep, left_fp_load;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int TOP = (s + 1) * INSTR_W - 1;

    slot_decode #(.NREG(NREG)) u_dec (
      .ctl_i      (bundle[TOP -: CTL_W]),
      .regs_i     (bundle[TOP - OP_W -: 3*REG_W]),
      .int_class_o(int_cls[s]),
      .rd_o       (rd[s]),
      .rs1_o      (rs1[s]),
      .rs2_o      (rs2[s]),
      .rd_we_o    (rd_we[s]),
      .rd_fp_o    (rd_fp[s]),
      .rs1_re_o   (rs1_re[s]),
      .rs2_re_o   (rs2_re[s]),
      .rs2_fp_o   (rs2_fp[s]),
      .rs1_fp_o   (rs1_fp[s])
    );

    busy_check #(.NREG(NREG)) u_busy (
      .rd_i      (rd[s]),
      .rs1_i     (rs1[s]),
      .rs2_i     (rs2[s]),
      .rd_we_i   (rd_we[s]),
      .rd_fp_i   (rd_fp[s]),
      .rs1_re_i  (rs1_re[s]),
      .rs1_fp_i  (rs1_fp[s]),
      .rs2_re_i  (rs2_re[s]),
      .rs2_fp_i  (rs2_fp[s]),
      .int_busy_i(int_busy_i),
      .fp_busy_i (fp_busy_i),
      .blocked_o (blocked[s])
    );
  end

  // only an FP load on the left can feed the right FP op
  assign left_fp_load = int_cls[0] && rd_we[0] && rd_fp[0];
  assign pair_dep = left_fp_load &&
                    ((rd[0] == rs1[1]) || (rd[0] == rs2[1]) || (rd[0] == rd[1]));

  issue_ctrl #(.BUNDLE_W(BUNDLE_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fetch_valid_i  (fetch_valid_i),
    .fetch_bundle_i (fetch_bundle_i),
    .stall_i        (stall_i),
    .left_int_i     (int_cls[0]),
    .right_fp_i     (!int_cls[1]),
    .pair_dep_i     (pair_dep),
    .left_blocked_i (blocked[0]),
    .right_blocked_i(blocked[1]),
    .fetch_ready_o  (fetch_ready_o),
    .issue_left_o   (issue_left_o),
    .issue_right_o  (issue_right_o),
    .bundle_o       (bundle)
  );

  assign left_instr_o  = bundle[INSTR_W-1:0];
  assign right_instr_o = bundle[BUNDLE_W-1:INSTR_W];

  // R6
  pair_dep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_left_o && pair_dep) |-> !issue_right_o);

  // R5
  class_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_left_o && !(int_cls[0] && !int_cls[1])) |-> !issue_right_o);
endmodule

// File: tb/dual_issue_pair_test.sv
`timescale 1ns/1ps
module dual_issue_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [63:0] fetch_bundle = '0;
  logic        stall = 1'b0;
  logic [31:0] int_busy = '0;
  logic [31:0] fp_busy = '0;
  logic        fetch_ready, issue_left, issue_right;
  logic [31:0] left_instr, right_instr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_issue_pair uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .fetch_valid_i (fetch_valid),
    .fetch_bundle_i(fetch_bundle),
    .fetch_ready_o (fetch_ready),
    .stall_i       (stall),
    .int_busy_i    (int_busy),
    .fp_busy_i     (fp_busy),
    .issue_left_o  (issue_left),
    .issue_right_o (issue_right),
    .left_instr_o  (left_instr),
    .right_instr_o (right_instr)
  );

  // opcodes (R3): ALU, int load, FP load, int store, FP store, branch, FP op
  localparam logic [5:0] OPS [7] = '{6'b000000, 6'b010000, 6'b010100,
                                     6'b011000, 6'b011100, 6'b100000, 6'b110000};

  function automatic logic [31:0] mk(input logic [5:0] op, input int rd, input int a, input int b);
    return {op, 5'(rd), 5'(a), 5'(b), 11'h2A5};
  endfunction

  // R7 register usage, written from the requirement text
  function automatic logic blk(input logic [31:0] i, input logic [31:0] ib, input logic [31:0] fb);
    logic [4:0] rd, a, b;
    rd = i[25:21]; a = i[20:16]; b = i[15:11];
    case (i[31:30])
      2'b00: return ib[rd] | ib[a] | ib[b];
      2'b01: return i[29] ? (ib[a] | (i[28] ? fb[b] : ib[b]))
                          : (ib[a] | (i[28] ? fb[rd] : ib[rd]));
      2'b10: return ib[a] | ib[b];
      default: return fb[rd] | fb[a] | fb[b];
    endcase
  endfunction

  function automatic logic dep(input logic [31:0] l, input logic [31:0] r);
    return (l[31:28] == 4'b0101) && (r[31:30] == 2'b11) &&
           (l[25:21] == r[25:21] || l[25:21] == r[20:16] || l[25:21] == r[15:11]);
  endfunction

  function automatic logic [1:0] exp_iss(input logic [1:0] pend, input logic [31:0] l, input logic [31:0] r,
                                         input logic [31:0] ib, input logic [31:0] fb, input logic st);
    logic il, ir;
    il = !st && pend[0] && !blk(l, ib, fb);
    if (pend[0])
      ir = il && pend[1] && !blk(r, ib, fb) && (l[31:30] != 2'b11) &&
           (r[31:30] == 2'b11) && !dep(l, r);
    else
      ir = !st && pend[1] && !blk(r, ib, fb);
    return {ir, il};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    fetch_valid = 1'b0; stall = 1'b0; int_busy = '0; fp_busy = '0;
    repeat (3) @(posedge clk);
  endtask

  task automatic trial(input logic [31:0] l, input logic [31:0] r,
                       input logic [31:0] ib, input logic [31:0] fb, input logic st);
    logic [1:0] e, rem;
    string tag;
    drain();
    @(negedge clk);
    fetch_valid = 1'b1; fetch_bundle = {r, l};
    @(posedge clk);
    @(negedge clk);
    fetch_valid = 1'b0; int_busy = ib; fp_busy = fb; stall = st;
    #1;
    if (st) tag = "R11";
    else if (blk(l, ib, fb)) tag = "R7,R8";
    else if (blk(r, ib, fb)) tag = "R7";
    else if (dep(l, r)) tag = "R6";
    else if (l[31:30] == 2'b11 || r[31:30] != 2'b11) tag = "R5";
    else tag = "R3,R4";
    e = exp_iss(2'b11, l, r, ib, fb, st);
    check(tag, {30'd0, issue_right, issue_left}, {30'd0, e});
    check("R2 left", left_instr, l);
    check("R2 right", right_instr, r);
    rem = 2'b11 & ~e;
    check("R10 ready", {31'd0, fetch_ready}, {31'd0, rem == 2'b00});
    @(posedge clk);
    @(negedge clk);
    int_busy = '0; fp_busy = '0; stall = 1'b0;
    #1;
    e = exp_iss(rem, l, r, '0, '0, 1'b0);
    check("R9 drain", {30'd0, issue_right, issue_left}, {30'd0, e});
    check("R9 ready", {31'd0, fetch_ready}, {31'd0, (rem & ~e) == 2'b00});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] l, r, l2, r2;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 ready", {31'd0, fetch_ready}, 32'd1);
    check("R1 issue", {30'd0, issue_right, issue_left}, 32'd0);

    for (int li = 0; li < 7; li++) begin
      for (int ri = 0; ri < 7; ri++) begin
        for (int d = 0; d < 4; d++) begin
          for (int bv = 0; bv < 5; bv++) begin
            int ldst;
            logic [31:0] ib, fb;
            ldst = (d == 0) ? 5 : (d == 1) ? 2 : (d == 2) ? 3 : 4;
            l = mk(OPS[li], ldst, 6, 7);
            r = mk(OPS[ri], 4, 2, 3);
            ib = '0; fb = '0;
            case (bv)
              1: ib[6] = 1'b1;
              2: fb[3] = 1'b1;
              3: begin ib[ldst] = 1'b1; fb[ldst] = 1'b1; end
              default: ;
            endcase
            trial(l, r, ib, fb, bv == 4);
          end
        end
      end
    end

    // R10: capture on the edge where the last pending instructions issue
    drain();
    l  = mk(6'b000000, 9, 10, 11);
    r  = mk(6'b110000, 12, 13, 14);
    l2 = mk(6'b100000, 1, 2, 3);
    r2 = mk(6'b110000, 15, 16, 17);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_bundle = {r, l};
    @(posedge clk);
    @(negedge clk);
    fetch_bundle = {r2, l2};
    #1;
    check("R10 pair issue", {30'd0, issue_right, issue_left}, 32'd3);
    check("R10 ready same cycle", {31'd0, fetch_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    fetch_valid = 1'b0;
    #1;
    check("R10 new left", left_instr, l2);
    check("R10 new right", right_instr, r2);
    check("R10 new pair", {30'd0, issue_right, issue_left}, 32'd3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule